// File: doc/BRIEF.md
# Subroutine call and return sequencer

This block runs the memory traffic of four stack operations for an 8-bit processor whose stack grows downward. The four operations are a subroutine call, a subroutine return, a one-byte push and a one-byte pull. It owns the stack pointer. It drives a single memory port that carries an address, write data, a write enable and read data returned in the same cycle. When an operation ends it delivers the new program counter or the pulled byte, together with a one-cycle completion strobe.

An operation starts when `start` is high while the sequencer is idle. The operation code is sampled at that edge: 0 is call, 1 is return, 2 is push and 3 is pull. `pc_in` and `push_data` are sampled at the same edge.

For a call, `pc_in` is the address of the first target byte, the one that follows the opcode. The value pushed is `pc_in + 1`, which is the address of the final byte of the call instruction. A return therefore adds one to the word it pops.

Every stack address has the stack page in its upper byte and the stack pointer in its lower byte. The stack page defaults to 0x01.

Top module: `callret_seq`

## Requirements
- R1: After reset, `sp_out` is 0xFF, and `busy`, `done` and `mem_we` are all 0.
- R2: A push (op 2) takes one cycle. In that cycle it writes the sampled `push_data` at {page, sp}. The stack pointer then drops by one.
- R3: A pull (op 3) takes two cycles. The first cycle raises the stack pointer by one and makes no write. The second cycle reads at {page, new sp}, and that byte appears on `pull_data`.
- R4: A call (op 0) takes five cycles, in this order:
  - Cycle 1 reads at `pc_in`; this byte is the target low byte.
  - Cycle 2 is idle.
  - Cycle 3 writes the upper byte of `pc_in+1` at {page, sp}.
  - Cycle 4 writes the lower byte of `pc_in+1` at {page, sp-1}.
  - Cycle 5 reads at `pc_in+1`; this byte is the target high byte.
  - The stack pointer ends two lower.
- R5: When a call completes, `pc_out` holds the target high byte joined above the target low byte.
- R6: A return (op 1) takes four cycles, in this order:
  - Cycle 1 is idle and raises the stack pointer.
  - Cycle 2 reads the low byte at {page, sp+1}.
  - Cycle 3 reads the high byte at {page, sp+2}.
  - Cycle 4 is idle.
  - The stack pointer ends two higher.
- R7: The stack pointer wraps modulo 256. A pull at 0xFF leaves it at 0x00, and a push at 0x00 leaves it at 0xFF.
- R8: `mem_we` is high only in the two push cycles of a call and in the one cycle of a push. Every write lands in the stack page.
- R9: A `start` that arrives while `busy` is high is ignored, and `pc_in` and `push_data` may change mid-operation without effect.
- R10: `busy` is high in every cycle of an operation. `done` is a single-cycle pulse in the cycle after the last one, with `busy` low.
- R11: On a return, `pc_out` is the popped word plus one, wrapping over 16 bits, so 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | 0 call, 1 return, 2 push, 3 pull |
| pc_in | input | 16 | For a call, address of the first target byte |
| push_data | input | 8 | Byte to push |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, same cycle as address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | New program counter after call or return |
| pull_data | output | 8 | Byte read by the last pull |
| sp_out | output | 8 | Current stack pointer |

## Verification
Directed cases come first:
- A pull straight after reset, which wraps the pointer from 0xFF to 0x00.
- A push at 0x00, which wraps it back to 0xFF.
- A call that receives a stray start and changed inputs in mid-flight. This separates a sequencer that locks its inputs from one that resamples them.
- A return of a word it just pushed. This shows the plus-one correction and the low-then-high slot order.
- A return of 0xFFFF, which exposes a 16-bit wrap error.

After these, several hundred operations are drawn at random, with random targets and data. Their mixed order walks the stack pointer across the wrap in both directions. Each cycle's address, write enable and write data is compared with a per-cycle expectation, so any reordered, missing or extra cycle shows up.

// File: rtl/callret_pkg.sv
package callret_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2 * DW;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RET  = 2'd1,
    OP_PUSH = 2'd2,
    OP_PULL = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_C_LO, S_C_GAP, S_C_WH, S_C_WL, S_C_HI,
    S_R_UP, S_R_LO, S_R_HI, S_R_END,
    S_P_WR,
    S_U_UP, S_U_RD
  } state_e;

  typedef enum logic [1:0] {
    A_PC,
    A_STK,
    A_STK1
  } asel_e;

  typedef enum logic [1:0] {
    W_PCH,
    W_PCL,
    W_ACC
  } wsel_e;

  function automatic addr_t stack_addr(input byte_t page, input byte_t sp);
    return {page, sp};
  endfunction

  function automatic byte_t sp_down(input byte_t sp);
    return sp - byte_t'(1);
  endfunction

  function automatic byte_t sp_up(input byte_t sp);
    return sp + byte_t'(1);
  endfunction

  function automatic addr_t addr_inc(input addr_t a);
    return a + addr_t'(1);
  endfunction
endpackage

// File: rtl/callret_sp_unit.sv
module callret_sp_unit
  import callret_pkg::*;
#(
  parameter byte_t SP_RESET = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc,
  input  logic  dec,
  output byte_t sp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= SP_RESET;
    end else if (inc) begin
      sp <= sp_up(sp);
    end else if (dec) begin
      sp <= sp_down(sp);
    end
  end
endmodule

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  op_e   op,
  output logic  accept,
  output logic  busy,
  output logic  we,
  output asel_e asel,
  output wsel_e wsel,
  output logic  sp_inc,
  output logic  sp_dec,
  output logic  cap_lo,
  output logic  cap_rlo,
  output logic  cap_rhi,
  output logic  fin_call,
  output logic  fin_ret,
  output logic  fin_push,
  output logic  fin_pull,
  output logic  call_hi_wr
);
  state_e state, nxt;

  assign accept = start && (state == S_IDLE);
  assign busy   = (state != S_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          unique case (op)
            OP_CALL: nxt = S_C_LO;
            OP_RET:  nxt = S_R_UP;
            OP_PUSH: nxt = S_P_WR;
            OP_PULL: nxt = S_U_UP;
            default: nxt = S_IDLE;
          endcase
        end
      end
      S_C_LO:  nxt = S_C_GAP;
      S_C_GAP: nxt = S_C_WH;
      S_C_WH:  nxt = S_C_WL;
      S_C_WL:  nxt = S_C_HI;
      S_C_HI:  nxt = S_IDLE;
      S_R_UP:  nxt = S_R_LO;
      S_R_LO:  nxt = S_R_HI;
      S_R_HI:  nxt = S_R_END;
      S_R_END: nxt = S_IDLE;
      S_P_WR:  nxt = S_IDLE;
      S_U_UP:  nxt = S_U_RD;
      S_U_RD:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    we         = 1'b0;
    asel       = A_STK;
    wsel       = W_ACC;
    sp_inc     = 1'b0;
    sp_dec     = 1'b0;
    cap_lo     = 1'b0;
    cap_rlo    = 1'b0;
    cap_rhi    = 1'b0;
    fin_call   = 1'b0;
    fin_ret    = 1'b0;
    fin_push   = 1'b0;
    fin_pull   = 1'b0;
    call_hi_wr = 1'b0;
    unique case (state)
      S_C_LO: begin
        asel   = A_PC;
        cap_lo = 1'b1;
      end
      S_C_WH: begin
        we         = 1'b1;
        wsel       = W_PCH;
        sp_dec     = 1'b1;
        call_hi_wr = 1'b1;
      end
      S_C_WL: begin
        we     = 1'b1;
        wsel   = W_PCL;
        sp_dec = 1'b1;
      end
      S_C_HI: begin
        asel     = A_PC;
        fin_call = 1'b1;
      end
      S_R_UP:  sp_inc = 1'b1;
      S_R_LO:  cap_rlo = 1'b1;
      S_R_HI: begin
        asel    = A_STK1;
        cap_rhi = 1'b1;
        sp_inc  = 1'b1;
      end
      S_R_END: fin_ret = 1'b1;
      S_P_WR: begin
        we       = 1'b1;
        wsel     = W_ACC;
        sp_dec   = 1'b1;
        fin_push = 1'b1;
      end
      S_U_UP:  sp_inc = 1'b1;
      S_U_RD:  fin_pull = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/callret_datapath.sv
module callret_datapath
  import callret_pkg::*;
#(
  parameter byte_t STACK_PAGE = 8'h01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  addr_t pc_in,
  input  byte_t push_data,
  input  byte_t mem_rdata,
  input  byte_t sp,
  input  asel_e asel,
  input  wsel_e wsel,
  input  logic  cap_lo,
  input  logic  cap_rlo,
  input  logic  cap_rhi,
  input  logic  fin_call,
  input  logic  fin_ret,
  input  logic  fin_push,
  input  logic  fin_pull,
  output addr_t mem_addr,
  output byte_t mem_wdata,
  output addr_t pc_out,
  output byte_t pull_data,
  output logic  done
);
  addr_t pc_r;
  byte_t acc_r, lo_r, rlo_r, rhi_r;

  always_comb begin
    unique case (asel)
      A_PC:    mem_addr = pc_r;
      A_STK1:  mem_addr = stack_addr(STACK_PAGE, sp_up(sp));
      default: mem_addr = stack_addr(STACK_PAGE, sp);
    endcase
  end

  always_comb begin
    unique case (wsel)
      W_PCH:   mem_wdata = pc_r[AW-1:DW];
      W_PCL:   mem_wdata = pc_r[DW-1:0];
      default: mem_wdata = acc_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_r      <= '0;
      acc_r     <= '0;
      lo_r      <= '0;
      rlo_r     <= '0;
      rhi_r     <= '0;
      pc_out    <= '0;
      pull_data <= '0;
      done      <= 1'b0;
    end else begin
      done <= fin_call | fin_ret | fin_push | fin_pull;
      if (accept) begin
        pc_r  <= pc_in;
        acc_r <= push_data;
      end
      if (cap_lo) begin
        lo_r <= mem_rdata;
        pc_r <= addr_inc(pc_r);
      end
      if (cap_rlo)  rlo_r     <= mem_rdata;
      if (cap_rhi)  rhi_r     <= mem_rdata;
      if (fin_call) pc_out    <= {mem_rdata, lo_r};
      if (fin_ret)  pc_out    <= addr_inc({rhi_r, rlo_r});
      if (fin_pull) pull_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter byte_t STACK_PAGE = 8'h01,
  parameter byte_t SP_RESET   = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] push_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] pull_data,
  output logic [DW-1:0] sp_out
);
  logic  accept, sp_inc_ev, sp_dec_ev, call_hi_wr;
  logic  cap_lo, cap_rlo, cap_rhi;
  logic  fin_call, fin_ret, fin_push, fin_pull;
  asel_e asel;
  wsel_e wsel;
  byte_t sp;

  callret_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op_e'(op)),
    .accept     (accept),
    .busy       (busy),
    .we         (mem_we),
    .asel       (asel),
    .wsel       (wsel),
    .sp_inc     (sp_inc_ev),
    .sp_dec     (sp_dec_ev),
    .cap_lo     (cap_lo),
    .cap_rlo    (cap_rlo),
    .cap_rhi    (cap_rhi),
    .fin_call   (fin_call),
    .fin_ret    (fin_ret),
    .fin_push   (fin_push),
    .fin_pull   (fin_pull),
    .call_hi_wr (call_hi_wr)
  );

  callret_sp_unit #(.SP_RESET(SP_RESET)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (sp_inc_ev),
    .dec   (sp_dec_ev),
    .sp    (sp)
  );

  callret_datapath #(.STACK_PAGE(STACK_PAGE)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .pc_in     (pc_in),
    .push_data (push_data),
    .mem_rdata (mem_rdata),
    .sp        (sp),
    .asel      (asel),
    .wsel      (wsel),
    .cap_lo    (cap_lo),
    .cap_rlo   (cap_rlo),
    .cap_rhi   (cap_rhi),
    .fin_call  (fin_call),
    .fin_ret   (fin_ret),
    .fin_push  (fin_push),
    .fin_pull  (fin_pull),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_out    (pc_out),
    .pull_data (pull_data),
    .done      (done)
  );

  assign sp_out = sp;
endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk
  import callret_pkg::*;
#(
  parameter byte_t STACK_PAGE = 8'h01
) (
  input logic  clk,
  input logic  rst_n,
  input logic  mem_we,
  input addr_t mem_addr,
  input logic  busy,
  input logic  done,
  input byte_t sp_out,
  input logic  sp_inc_ev,
  input logic  sp_dec_ev,
  input logic  call_hi_wr
);
  // R8
  we_in_stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[AW-1:DW] == STACK_PAGE);

  // R8
  we_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R2
  sp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_dec_ev |=> sp_out == byte_t'($past(sp_out) - byte_t'(1)));

  // R3
  sp_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_inc_ev |=> sp_out == byte_t'($past(sp_out) + byte_t'(1)));

  // R4
  call_low_follows_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_hi_wr |=> mem_we && (mem_addr[DW-1:0] == byte_t'($past(mem_addr[DW-1:0]) - byte_t'(1))));

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind callret_seq callret_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_callret_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .done       (done),
  .sp_out     (sp_out),
  .sp_inc_ev  (sp_inc_ev),
  .sp_dec_ev  (sp_dec_ev),
  .call_hi_wr (call_hi_wr)
);

// File: tb/test_callret_seq.sv
`timescale 1ns/1ps
module test_callret_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  push_data = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [15:0] pc_out;
  logic [7:0]  pull_data, sp_out;

  int vectors = 0;
  int errors  = 0;
  bit ended   = 0;
  logic [7:0] stk [256];
  logic [7:0] exp_sp;

  always #10 clk = ~clk;

  callret_seq i_callret_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
    .push_data(push_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_out(pc_out), .pull_data(pull_data), .sp_out(sp_out)
  );

  function automatic logic [7:0] romv(input logic [15:0] a);
    return (a[7:0] ^ {a[3:0], a[7:4]}) + a[15:8] + 8'h17;
  endfunction

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : romv(mem_addr);

  always @(posedge clk)
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] = mem_wdata;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic do_op(input logic [1:0] o, input logic [15:0] p,
                       input logic [7:0] d, input bit poke);
    logic [15:0] ea [5];
    logic        ew [5];
    logic [7:0]  ewd [5];
    bit          ca [5];
    int          n;
    logic [15:0] epc, p1;
    logic [7:0]  epull, s, s1, s2, sm;
    string       rq;
    s = exp_sp; s1 = s + 8'd1; s2 = s + 8'd2; sm = s - 8'd1;
    p1 = p + 16'd1;
    epc = '0; epull = '0; n = 1; rq = "R2";
    for (int i = 0; i < 5; i++) begin
      ea[i] = '0; ew[i] = 1'b0; ewd[i] = '0; ca[i] = 1'b0;
    end
    case (o)
      2'd0: begin
        n = 5; rq = "R4";
        ea[0] = p; ca[0] = 1;
        ea[2] = {8'h01, s};  ca[2] = 1; ew[2] = 1; ewd[2] = p1[15:8];
        ea[3] = {8'h01, sm}; ca[3] = 1; ew[3] = 1; ewd[3] = p1[7:0];
        ea[4] = p1; ca[4] = 1;
        epc = {romv(p1), romv(p)};
        exp_sp = s - 8'd2;
      end
      2'd1: begin
        n = 4; rq = "R6";
        ea[1] = {8'h01, s1}; ca[1] = 1;
        ea[2] = {8'h01, s2}; ca[2] = 1;
        epc = {stk[s2], stk[s1]} + 16'd1;
        exp_sp = s2;
      end
      2'd2: begin
        n = 1; rq = "R2";
        ea[0] = {8'h01, s}; ca[0] = 1; ew[0] = 1; ewd[0] = d;
        exp_sp = sm;
      end
      default: begin
        n = 2; rq = "R3";
        ea[1] = {8'h01, s1}; ca[1] = 1;
        epull = stk[s1];
        exp_sp = s1;
      end
    endcase
    start = 1'b1; op = o; pc_in = p; push_data = d;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(busy == 1'b1, "R10", "busy in sequence", {31'd0, busy}, 32'd1);
      chk(mem_we == ew[i], "R8", "write enable", {31'd0, mem_we}, {31'd0, ew[i]});
      if (ca[i]) chk(mem_addr == ea[i], rq, "address", {16'd0, mem_addr}, {16'd0, ea[i]});
      if (ew[i]) chk(mem_wdata == ewd[i], rq, "write data", {24'd0, mem_wdata}, {24'd0, ewd[i]});
      if (poke && i == 0) begin
        // R9: stray start and changed inputs while busy
        start = 1'b1; op = 2'd3; pc_in = ~p; push_data = ~d;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R10", "done strobe", {31'd0, done}, 32'd1);
    chk(busy == 1'b0, "R10", "busy after", {31'd0, busy}, 32'd0);
    chk(sp_out == exp_sp, rq, "stack pointer", {24'd0, sp_out}, {24'd0, exp_sp});
    if (o == 2'd0) chk(pc_out == epc, "R5", "call target", {16'd0, pc_out}, {16'd0, epc});
    if (o == 2'd1) chk(pc_out == epc, "R6", "return pc", {16'd0, pc_out}, {16'd0, epc});
    if (o == 2'd3) chk(pull_data == epull, "R3", "pulled byte", {24'd0, pull_data}, {24'd0, epull});
    @(negedge clk);
    chk(done == 1'b0, "R10", "done drops", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rp;
    for (int i = 0; i < 256; i++) stk[i] = 8'(i) ^ 8'h5A;
    void'($urandom(32'd7321));
    exp_sp = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sp_out == 8'hFF, "R1", "reset sp", {24'd0, sp_out}, 32'hFF);
    chk(busy == 1'b0, "R1", "reset busy", {31'd0, busy}, 32'd0);
    chk(done == 1'b0, "R1", "reset done", {31'd0, done}, 32'd0);
    chk(mem_we == 1'b0, "R1", "reset we", {31'd0, mem_we}, 32'd0);

    // R7: pull at 0xFF wraps to 0x00, push at 0x00 wraps to 0xFF
    do_op(2'd3, 16'h0000, 8'h00, 0);
    chk(sp_out == 8'h00, "R7", "pull wrap", {24'd0, sp_out}, 32'h00);
    do_op(2'd2, 16'h0000, 8'h3C, 0);
    chk(sp_out == 8'hFF, "R7", "push wrap", {24'd0, sp_out}, 32'hFF);
    chk(stk[8'h00] == 8'h3C, "R2", "pushed byte", {24'd0, stk[8'h00]}, 32'h3C);

    // R9: call with stray start mid-sequence
    do_op(2'd0, 16'h2000, 8'h00, 1);
    chk(sp_out == 8'hFD, "R9", "sp unaffected by stray start", {24'd0, sp_out}, 32'hFD);

    // return of the pushed address 0x2001 gives 0x2002
    do_op(2'd1, 16'h0000, 8'h00, 0);
    chk(pc_out == 16'h2002, "R6", "return plus one", {16'd0, pc_out}, 32'h2002);

    // R11: popped 0xFFFF wraps to 0x0000
    do_op(2'd2, 16'h0000, 8'hFF, 0);
    do_op(2'd2, 16'h0000, 8'hFF, 0);
    do_op(2'd1, 16'h0000, 8'h00, 0);
    chk(pc_out == 16'h0000, "R11", "return wrap", {16'd0, pc_out}, 32'h0);

    for (int k = 0; k < 400; k++) begin
      rp = 16'($urandom);
      if (rp[15:8] < 8'd2) rp[15:8] = rp[15:8] ^ 8'h80;
      do_op(2'($urandom % 4), rp, 8'($urandom), 0);
    end

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule